// File: doc/BRIEF.md
# Shared-Control Register Cluster

This block is a group of single-bit storage cells that share one clock, one clock-enable line and one set/reset line, as found in the logic tiles of a programmable fabric. Each cell captures its own data bit on the rising clock edge. The clock enable and the set/reset line are common to the whole group. Static configuration ports decide how the cells respond to them.

Configuration selects whether the clock enable gates capture or is ignored. It also selects whether the shared set/reset line is honoured at all, and whether it acts at once or waits for the next clock edge. A per-cell polarity bit turns the common line into a set for some cells and a reset for others. A one-cycle configuration-done pulse clears every cell, and it does so even when set/reset is disabled.

A chip-level active-low reset clears all cells asynchronously. Its release is synchronised to the clock inside the block.

Top module: `srcl_cluster`

## Requirements
- R1: While `rst_n` is low, every bit of `q` is 0 without waiting for a clock edge. After `rst_n` rises, the cells start normal operation within two clock edges.
- R2: With `cfg_ce_used`=1, a cell loads `d` at a rising edge only if `ce`=1. If `ce`=0, the cell keeps its value.
- R3: With `cfg_ce_used`=0, every cell loads `d` at every rising edge, whatever the level of `ce`.
- R4: With `cfg_sr_used`=1 and `cfg_sr_async`=0, `sr`=1 at a rising edge makes `q[i]` equal `cfg_sr_pol[i]` (1 sets the cell, 0 clears it). This beats `d` and also beats a low `ce`.
- R5: With `cfg_sr_used`=1 and `cfg_sr_async`=1, a rise of `sr` drives `q[i]` to `cfg_sr_pol[i]` at once, with no clock edge. `q` stays there across edges for as long as `sr` is held.
- R6: In the immediate mode, after `sr` falls, `q` keeps its forced value until the first rising edge. Normal capture resumes at that edge.
- R7: With `cfg_sr_used`=0, `sr` has no effect on `q` in either mode, at any level.
- R8: A high `cfg_done` at a rising edge clears every cell to 0. It beats `d`, `ce` and the clock-edge set/reset, and it clears the cells whether or not set/reset is enabled.
- R9: One pulse on the shared `sr` line acts on all cells at the same moment, each cell according to its own polarity bit. A mixed polarity pattern yields that exact pattern on `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Chip reset, active low, asynchronous assert |
| cfg_ce_used | input | 1 | 1: `ce` gates capture; 0: capture every edge |
| cfg_sr_used | input | 1 | 1: `sr` is honoured; 0: `sr` ignored |
| cfg_sr_async | input | 1 | 1: `sr` acts immediately; 0: at the clock edge |
| cfg_sr_pol | input | CELLS | Per-cell action of `sr`: 1 set, 0 clear |
| cfg_done | input | 1 | One-cycle pulse clearing all cells |
| ce | input | 1 | Shared clock enable, active high |
| sr | input | 1 | Shared set/reset, active high |
| d | input | CELLS | Data into each cell |
| q | output | CELLS | Stored value of each cell |

## Verification
A wrong selection of the next state, such as capture leaking through a low enable or set/reset beating the configuration-done clear, shows on `q` at the first rising edge after the stimulus. A wrong polarity shows as a bit that does not match `cfg_sr_pol`. In the immediate mode the forced value must be visible on `q` before any clock edge. The bench therefore samples shortly after `sr` rises. It samples again just after `sr` falls, to show that release alone changes nothing until the next edge.

// File: rtl/srcl_pkg.sv
package srcl_pkg;
  localparam int unsigned SRCL_CELLS = 8;
  localparam int unsigned SRCL_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    SR_OFF   = 2'b00,
    SR_EDGE  = 2'b01,
    SR_IMMED = 2'b10
  } sr_mode_e;
endpackage

// File: rtl/srcl_rst_sync.sv
module srcl_rst_sync #(
  parameter int unsigned STAGES = srcl_pkg::SRCL_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

  // R1: a released chain has all stages high once the output is high
  a_r1_rst_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> $past(chain_q[0]));
endmodule

// File: rtl/srcl_ctrl.sv
module srcl_ctrl
  import srcl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_ce_used,
  input  logic cfg_sr_used,
  input  logic cfg_sr_async,
  input  logic ce,
  input  logic sr,
  output logic cap_en,
  output logic sync_force,
  output logic async_force
);
  sr_mode_e mode;

  always_comb begin
    if (!cfg_sr_used)      mode = SR_OFF;
    else if (cfg_sr_async) mode = SR_IMMED;
    else                   mode = SR_EDGE;
  end

  always_comb begin
    cap_en      = cfg_ce_used ? ce : 1'b1;
    sync_force  = 1'b0;
    async_force = 1'b0;
    case (mode)
      SR_EDGE:  sync_force  = sr;
      SR_IMMED: async_force = sr;
      default: begin
        sync_force  = 1'b0;
        async_force = 1'b0;
      end
    endcase
  end

  // R7: a disabled line reaches neither force path
  a_r7_sr_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sr_used |-> !(sync_force || async_force));
endmodule

// File: rtl/srcl_cell.sv
module srcl_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_done,
  input  logic cap_en,
  input  logic sync_force,
  input  logic async_force,
  input  logic pol,
  input  logic d,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (cfg_done)        q_nxt = 1'b0;
    else if (sync_force) q_nxt = pol;
    else if (cap_en)     q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n or posedge async_force) begin
    if (!rst_n)           q <= 1'b0;
    else if (async_force) q <= pol;
    else                  q <= q_nxt;
  end

  a_r4_edge_force: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_force && !cfg_done) |=> (q == pol));

  a_r5_immed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    async_force |-> (q == pol));

  a_r8_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && !async_force) |=> (async_force || !q));

  a_r2_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !sync_force && !cfg_done && !async_force)
      |=> (async_force || q == $past(q)));
endmodule

// File: rtl/srcl_cluster.sv
module srcl_cluster
  import srcl_pkg::*;
#(
  parameter int unsigned CELLS = SRCL_CELLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ce_used,
  input  logic             cfg_sr_used,
  input  logic             cfg_sr_async,
  input  logic [CELLS-1:0] cfg_sr_pol,
  input  logic             cfg_done,
  input  logic             ce,
  input  logic             sr,
  input  logic [CELLS-1:0] d,
  output logic [CELLS-1:0] q
);
  logic rst_sync_n;
  logic cap_en;
  logic sync_force;
  logic async_force;

  srcl_rst_sync #(.STAGES(SRCL_SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  srcl_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cfg_ce_used  (cfg_ce_used),
    .cfg_sr_used  (cfg_sr_used),
    .cfg_sr_async (cfg_sr_async),
    .ce           (ce),
    .sr           (sr),
    .cap_en       (cap_en),
    .sync_force   (sync_force),
    .async_force  (async_force)
  );

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    srcl_cell u_cell (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .cfg_done    (cfg_done),
      .cap_en      (cap_en),
      .sync_force  (sync_force),
      .async_force (async_force),
      .pol         (cfg_sr_pol[i]),
      .d           (d[i]),
      .q           (q[i])
    );
  end

  // R3: with no force and no clear, an enabled edge loads d into every cell
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cap_en && !cfg_done && !sync_force && !async_force)
      |=> (async_force || q == $past(d)));

  // R9: the edge-mode force writes the whole polarity pattern at once
  a_r9_pattern: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sync_force && !cfg_done) |=> (q == cfg_sr_pol));
endmodule

// File: tb/sim_srcl_cluster.sv
`timescale 1ns/1ps
module sim_srcl_cluster;
  localparam int unsigned N = 8;
  localparam logic [N-1:0] POL = 8'b1010_0110;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_ce_used, cfg_sr_used, cfg_sr_async, cfg_done, ce, sr;
  logic [N-1:0] cfg_sr_pol, d, q;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  srcl_cluster #(.CELLS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_ce_used(cfg_ce_used), .cfg_sr_used(cfg_sr_used),
    .cfg_sr_async(cfg_sr_async), .cfg_sr_pol(cfg_sr_pol), .cfg_done(cfg_done),
    .ce(ce), .sr(sr), .d(d), .q(q)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic test_reset();
    rst_n = 1'b0; cfg_done = 0; ce = 0; sr = 0; d = '0;
    cfg_ce_used = 1; cfg_sr_used = 0; cfg_sr_async = 0; cfg_sr_pol = POL;
    repeat (3) tick();
    chk("R1 reset state", q, '0);
    rst_n = 1'b1;
    repeat (3) tick();
    ce = 1; d = 8'h5A; tick();
    chk("R1 running after release", q, 8'h5A);
    rst_n = 1'b0; #1;
    chk("R1 async assert", q, '0);
    tick(); rst_n = 1'b1; repeat (3) tick();
  endtask

  task automatic test_combo(input logic a, input logic u, input logic c);
    logic [N-1:0] held;
    cfg_sr_async = a; cfg_sr_used = u; cfg_ce_used = c;
    sr = 0; ce = 1; d = '1; cfg_done = 1; tick(); cfg_done = 0;
    chk("R8 done clear", q, '0);
    d = 8'h3C; ce = 1; tick();
    chk(c ? "R2 enabled load" : "R3 load", q, 8'h3C);
    d = 8'hC3; ce = 0; tick();
    chk(c ? "R2 hold on low ce" : "R3 ce ignored", q, c ? 8'h3C : 8'hC3);
    d = 8'h5A; ce = 1; tick();
    chk("R3 reload", q, 8'h5A);
    d = 8'h0F; ce = 0; sr = 1; #1;
    chk((u && a) ? "R5 immediate force" : "R7 no change before edge", q,
        (u && a) ? POL : 8'h5A);
    tick();
    held = u ? POL : (c ? 8'h5A : 8'h0F);
    chk(u ? (a ? "R5 hold across edge" : "R4 edge force beats ce") : "R7 sr ignored",
        q, held);
    tick();
    chk(u ? "R9 pattern kept" : "R7 sr still ignored", q, held);
    sr = 0; #1;
    chk("R6 release keeps value", q, held);
    d = 8'h99; ce = 1; tick();
    chk("R6 capture resumes", q, 8'h99);
    if (!a) begin
      sr = 1; cfg_done = 1; d = '1; tick();
      sr = 0; cfg_done = 0;
      chk("R8 done beats sr", q, '0);
    end
  endtask

  initial begin
    test_reset();
    for (int k = 0; k < 8; k++) test_combo(k[2], k[1], k[0]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule